// File: doc/BRIEF.md
# Transmit Length Fail-Safe Timer

This block sits between a serial bus encoder and the bus driver and watches how long the encoder keeps transmitting. The encoder drives a complementary pair of bus-level signals. A transmission is in progress whenever either signal of the pair is high. Short idle stretches inside a message still count as part of the same transmission. When one transmission runs past 768 µs of a 12 MHz timebase, the block raises a fail-safe flag and forces both outputs to the driver low, which cuts off a runaway transmitter.

The flag is sticky and stays set after the transmission stops. It clears in only two cases: the decoder reports a valid command word carrying this terminal's own address, or master reset goes low. Master reset clears only the flag. It leaves the length measurement alone, so a reset pulse that falls inside a short gap does not start a fresh message. A transmission that resumes within that gap therefore trips the flag again at once.

The timebase rate, the length limit and the gap tolerance are parameters. A parameter can also place a register stage on the gated outputs. The requirements below describe the default configuration: 12 clocks per µs, a 768 µs limit, a 3 µs gap and combinational output gating.

Top module: `tfs_failsafe_timer`

## Requirements
- R1: After `rst_n` is released, `fail_safe` is low and `bus_pos`/`bus_neg` follow `tx_pos`/`tx_neg`.
- R2: A clock cycle counts as transmitting when `tx_pos` or `tx_neg` is high at the rising edge. Starting from idle, 9216 counted cycles leave `fail_safe` low. The edge that counts cycle 9217 sets `fail_safe`, and it is visible right after that edge.
- R3: An idle run of up to 36 consecutive clocks does not end a transmission, and the idle clocks add to its length.
- R4: An idle run of 37 or more consecutive clocks ends the transmission, and the next transmission is measured from zero.
- R5: While `fail_safe` is high, `bus_pos` and `bus_neg` are both low. While it is low, they equal `tx_pos` and `tx_neg` in the same cycle.
- R6: Once set, `fail_safe` stays high through any activity or idle time until a clear condition is sampled.
- R7: `addr_match` sampled high at a rising edge makes `fail_safe` low after that edge.
- R8: `mrst_n` sampled low at a rising edge makes `fail_safe` low after that edge without resetting the length measurement. If transmission resumes within the same idle run of at most 36 clocks, its first cycle sets `fail_safe` again.
- R9: When a clear condition and a set condition meet at the same edge, the clear wins. The flag sets again on the next transmitting cycle that has no clear.
- R10: The length measurement saturates. A transmission that continues far beyond the limit keeps `fail_safe` high and never wraps back to a count that would drop it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 12 MHz timebase clock |
| rst_n | input | 1 | Asynchronous chip reset, active low; initialises all state |
| mrst_n | input | 1 | Master reset, active low, sampled; clears the fail-safe flag |
| tx_pos | input | 1 | Encoder output, positive bus level |
| tx_neg | input | 1 | Encoder output, negative bus level |
| addr_match | input | 1 | Pulse: valid command word with own terminal address received |
| bus_pos | output | 1 | Gated positive bus level to the driver |
| bus_neg | output | 1 | Gated negative bus level to the driver |
| fail_safe | output | 1 | Fail-safe flag, high after an over-long transmission |

## Verification
The hardest case to reach is a master reset that lands inside a short gap of a transmission already over the limit, followed by a resumed burst. That burst must re-trip on its first cycle, even though the flag was just cleared and the encoder stopped. The stimulus first drives a run of exactly 9216 counted cycles and then one more, to pin the trip edge. It then pulses master reset inside a gap of a few clocks and resumes, and it repeats the pattern with gaps of exactly 36 and 37 clocks to bracket the gap rule. Random bursts and random gap lengths near the 36/37 boundary then run against a cycle model of the requirements, with occasional clear pulses.

// File: rtl/tfs_pkg.sv
package tfs_pkg;
   // Default timebase and limits
   parameter int unsigned TFS_TICKS_PER_US = 12;
   parameter int unsigned TFS_LIMIT_US     = 768;
   parameter int unsigned TFS_GAP_US       = 3;

   // Counter width able to hold 0..max_val
   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/tfs_gap_tracker.sv
// Counts consecutive idle clocks; flags the clock that ends a message.
module tfs_gap_tracker #(
   parameter int unsigned GAP_CLKS = 36
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   output logic gap_expired
);
   localparam int unsigned GAP_SAT = GAP_CLKS + 1;
   localparam int unsigned GW      = tfs_pkg::cnt_width(GAP_SAT);

   logic [GW-1:0] gap_q;
   logic [GW-1:0] idle_n;

   always_comb begin
      idle_n = (gap_q == GW'(GAP_SAT)) ? gap_q : gap_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gap_q <= GW'(GAP_SAT);
      else        gap_q <= active ? '0 : idle_n;
   end

   assign gap_expired = !active && (idle_n == GW'(GAP_SAT));
endmodule

// File: rtl/tfs_len_counter.sv
// Saturating message-length counter; reports the over-limit condition.
module tfs_len_counter #(
   parameter int unsigned LIMIT_CLKS = 9216
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic gap_expired,
   output logic over
);
   localparam int unsigned LEN_SAT = LIMIT_CLKS + 1;
   localparam int unsigned LW      = tfs_pkg::cnt_width(LEN_SAT);

   logic [LW-1:0] len_q;
   logic [LW-1:0] len_inc;
   logic [LW-1:0] len_d;

   always_comb begin
      len_inc = (len_q == LW'(LEN_SAT)) ? len_q : len_q + 1'b1;
      if (gap_expired)                 len_d = '0;
      else if (active || len_q != '0)  len_d = len_inc;
      else                             len_d = len_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) len_q <= '0;
      else        len_q <= len_d;
   end

   assign over = active && (len_inc == LW'(LEN_SAT));
endmodule

// File: rtl/tfs_flag_latch.sv
// Sticky fail-safe flag; clear dominates set.
module tfs_flag_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic clr_req,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag <= 1'b0;
      else if (clr_req) flag <= 1'b0;
      else if (set_req) flag <= 1'b1;
   end
endmodule

// File: rtl/tfs_failsafe_timer.sv
module tfs_failsafe_timer #(
   parameter int unsigned TICKS_PER_US = tfs_pkg::TFS_TICKS_PER_US,
   parameter int unsigned LIMIT_US     = tfs_pkg::TFS_LIMIT_US,
   parameter int unsigned GAP_US       = tfs_pkg::TFS_GAP_US,
   parameter bit          OUT_REG      = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mrst_n,
   input  logic tx_pos,
   input  logic tx_neg,
   input  logic addr_match,
   output logic bus_pos,
   output logic bus_neg,
   output logic fail_safe
);
   localparam int unsigned LIMIT_CLKS = TICKS_PER_US * LIMIT_US;
   localparam int unsigned GAP_CLKS   = TICKS_PER_US * GAP_US;

   // Elaboration-time parameter checks
   if (TICKS_PER_US < 1) begin : g_bad_tick
      $error("TICKS_PER_US must be at least 1");
   end
   if (GAP_US >= LIMIT_US) begin : g_bad_gap
      $error("GAP_US must be below LIMIT_US");
   end

   logic active;
   logic gap_expired;
   logic over;
   logic clear;

   assign active = tx_pos | tx_neg;
   assign clear  = addr_match | ~mrst_n;

   tfs_gap_tracker #(.GAP_CLKS(GAP_CLKS)) u_gap (
      .clk         (clk),
      .rst_n       (rst_n),
      .active      (active),
      .gap_expired (gap_expired)
   );

   tfs_len_counter #(.LIMIT_CLKS(LIMIT_CLKS)) u_len (
      .clk         (clk),
      .rst_n       (rst_n),
      .active      (active),
      .gap_expired (gap_expired),
      .over        (over)
   );

   tfs_flag_latch u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_req (over),
      .clr_req (clear),
      .flag    (fail_safe)
   );

   if (OUT_REG) begin : g_out_reg
      logic pos_q, neg_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pos_q <= 1'b0;
            neg_q <= 1'b0;
         end else begin
            pos_q <= tx_pos & ~fail_safe;
            neg_q <= tx_neg & ~fail_safe;
         end
      end
      assign bus_pos = pos_q & ~fail_safe;
      assign bus_neg = neg_q & ~fail_safe;
   end else begin : g_out_comb
      assign bus_pos = tx_pos & ~fail_safe;
      assign bus_neg = tx_neg & ~fail_safe;
   end
endmodule

// File: rtl/tfs_failsafe_chk.sv
module tfs_failsafe_chk #(
   parameter bit OUT_REG = 1'b0
) (
   input logic clk,
   input logic rst_n,
   input logic mrst_n,
   input logic tx_pos,
   input logic tx_neg,
   input logic addr_match,
   input logic bus_pos,
   input logic bus_neg,
   input logic fail_safe
);
   // R5
   gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fail_safe |-> (!bus_pos && !bus_neg));

   if (!OUT_REG) begin : g_pass
      // R5
      pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !fail_safe |-> (bus_pos == tx_pos && bus_neg == tx_neg));
   end

   // R7
   addr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_match |=> !fail_safe);

   // R8
   mrst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mrst_n |=> !fail_safe);

   // R6
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_safe && !addr_match && mrst_n) |=> fail_safe);

   // R2
   rise_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail_safe) |-> $past(tx_pos || tx_neg));
endmodule

bind tfs_failsafe_timer tfs_failsafe_chk #(.OUT_REG(OUT_REG)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mrst_n     (mrst_n),
   .tx_pos     (tx_pos),
   .tx_neg     (tx_neg),
   .addr_match (addr_match),
   .bus_pos    (bus_pos),
   .bus_neg    (bus_neg),
   .fail_safe  (fail_safe)
);

// File: tb/tfs_failsafe_timer_tb.sv
module tfs_failsafe_timer_tb;
   localparam int LIMIT = 9216;
   localparam int SAT   = LIMIT + 1;
   localparam int GAPC  = 36;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mrst_n = 1'b1;
   logic tx_pos = 1'b0;
   logic tx_neg = 1'b0;
   logic addr_match = 1'b0;
   logic bus_pos, bus_neg, fail_safe;

   int n_chk = 0;
   int n_bad = 0;

   // reference model state
   int  m_idle = GAPC + 1;
   int  m_len  = 0;
   bit  m_fs   = 1'b0;

   always #10 clk = ~clk;

   tfs_failsafe_timer u_dut (
      .clk(clk), .rst_n(rst_n), .mrst_n(mrst_n),
      .tx_pos(tx_pos), .tx_neg(tx_neg), .addr_match(addr_match),
      .bus_pos(bus_pos), .bus_neg(bus_neg), .fail_safe(fail_safe)
   );

   function automatic int sat_add(input int v);
      return (v >= SAT) ? SAT : v + 1;
   endfunction

   task automatic model_edge(input bit p, input bit n, input bit am, input bit mr);
      bit act, over;
      act = p | n;
      over = 1'b0;
      if (act) begin
         m_idle = 0;
         m_len  = sat_add(m_len);
         over   = (m_len == SAT);
      end else begin
         m_idle = (m_idle > GAPC) ? GAPC + 1 : m_idle + 1;
         if (m_idle > GAPC) m_len = 0;
         else if (m_len != 0) m_len = sat_add(m_len);
      end
      if (am || !mr) m_fs = 1'b0;
      else if (over) m_fs = 1'b1;
   endtask

   task automatic check(input string tag, input string what, input int act_v, input int exp_v);
      n_chk++;
      if (act_v != exp_v) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act_v, exp_v);
      end
   endtask

   // one clock: drive at negedge, model at posedge, check at next negedge
   task automatic step(input bit p, input bit n, input bit am, input bit mr, input string tag);
      tx_pos = p; tx_neg = n; addr_match = am; mrst_n = mr;
      @(posedge clk);
      model_edge(p, n, am, mr);
      @(negedge clk);
      check(tag, "fail_safe", int'(fail_safe), int'(m_fs));
      check("R5", "bus pair", int'({bus_pos, bus_neg}), int'({p & ~m_fs, n & ~m_fs}));
   endtask

   task automatic burst(input int len, input string tag);
      for (int i = 0; i < len; i++) begin
         bit p, n;
         p = 1'($urandom_range(0, 1));
         n = ~p;
         if ($urandom_range(0, 7) == 0) n = 1'b1;
         step(p, n, 1'b0, 1'b1, tag);
      end
   endtask

   task automatic idle(input int len, input string tag);
      for (int i = 0; i < len; i++) step(1'b0, 1'b0, 1'b0, 1'b1, tag);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", "fail_safe after reset", int'(fail_safe), 0);
      check("R1", "bus pair idle", int'({bus_pos, bus_neg}), 0);
      step(1'b1, 1'b0, 1'b0, 1'b1, "R1");
      step(1'b0, 1'b1, 1'b0, 1'b1, "R1");
      idle(40, "R4");

      // R2: exact trip edge
      burst(LIMIT, "R2");
      check("R2", "no trip at limit", int'(fail_safe), 0);
      burst(1, "R2");
      check("R2", "trip after limit", int'(fail_safe), 1);
      // R10: long overrun keeps flag
      burst(2 * LIMIT, "R10");
      check("R10", "flag after 3x limit", int'(fail_safe), 1);
      idle(10, "R6");
      check("R6", "flag held idle", int'(fail_safe), 1);
      step(1'b0, 1'b0, 1'b1, 1'b1, "R7");
      check("R7", "cleared by address match", int'(fail_safe), 0);
      idle(40, "R4");

      // R3: 36-clock gap continues message
      burst(5000, "R3");
      idle(GAPC, "R3");
      burst(LIMIT - 5000 - GAPC, "R3");
      check("R3", "no trip at limit across gap", int'(fail_safe), 0);
      burst(1, "R3");
      check("R3", "trip across gap", int'(fail_safe), 1);
      // R8: master reset inside short gap, resume re-trips
      step(1'b0, 1'b0, 1'b0, 1'b0, "R8");
      step(1'b0, 1'b0, 1'b0, 1'b0, "R8");
      check("R8", "cleared by master reset", int'(fail_safe), 0);
      idle(3, "R8");
      burst(1, "R8");
      check("R8", "re-trip after resume", int'(fail_safe), 1);
      step(1'b0, 1'b0, 1'b0, 1'b0, "R8");
      idle(40, "R4");

      // R4: 37-clock gap restarts measurement
      burst(5000, "R4");
      idle(GAPC + 1, "R4");
      burst(LIMIT, "R4");
      check("R4", "no trip after restart", int'(fail_safe), 0);
      burst(1, "R4");
      check("R4", "trip after restart", int'(fail_safe), 1);
      // R9: clear beats set on same edge
      step(1'b1, 1'b0, 1'b1, 1'b1, "R9");
      check("R9", "clear wins", int'(fail_safe), 0);
      step(1'b0, 1'b1, 1'b0, 1'b1, "R9");
      check("R9", "set on next cycle", int'(fail_safe), 1);
      step(1'b0, 1'b0, 1'b0, 1'b0, "R8");
      idle(40, "R4");

      // random segments
      for (int s = 0; s < 30; s++) begin
         int g;
         burst($urandom_range(1, 2500), "R2");
         case ($urandom_range(0, 3))
            0: g = $urandom_range(1, GAPC);
            1: g = GAPC;
            2: g = GAPC + 1;
            default: g = $urandom_range(GAPC + 1, 80);
         endcase
         for (int k = 0; k < g; k++) begin
            bit am, mr;
            am = ($urandom_range(0, 60) == 0);
            mr = ($urandom_range(0, 60) != 0);
            step(1'b0, 1'b0, am, mr, "R6");
         end
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule